// File: doc/BRIEF.md
# MAC Statistics Counter Bank

This block keeps running tallies of frame activity for an Ethernet MAC. The transmit and receive datapaths each send it one-cycle event pulses. On the transmit side it counts every frame, frames that went out after exactly one collision, frames that went out after several collisions, and the bytes carried by good frames. On the receive side it counts every frame, frames with a bad CRC, frames with an alignment error, and good unicast frames. Each counter wraps to zero when it passes its full range.

Every counter has an interrupt status bit. The bit is set when the counter enters the upper half of its range or wraps. Receive and transmit each have their own status register and their own mask register. Each side drives a separate interrupt output. A control register can zero all counters, freeze them, or turn on clear-on-read. Everything is reached through a simple word-addressed write port and a registered read port.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset, every counter, both status registers, both mask registers and the control register read zero, and both interrupt outputs are low.
- R2: Each frame counter adds one on the clock edge that samples its event pulse, and wraps from all-ones to zero. Counter index 0 counts all transmit frames, 1 single-collision frames, 2 multiple-collision frames, 4 all receive frames, 5 CRC-error frames, 6 alignment-error frames and 7 good unicast frames.
- R3: Counter index 3 adds the value of `tx_good_bytes_i` on each `tx_good_i` pulse, modulo its full range.
- R4: The status bit of a counter is set one cycle after that counter's update, when the update moved the most significant bit from 0 to 1 or carried out of the top bit. Transmit status bits 0..3 belong to counters 0..3. Receive status bits 0..3 belong to counters 4..7.
- R5: Writing a status register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R6: Each interrupt output is high exactly when, one cycle earlier, its status register had a set bit whose mask bit was 0. A mask bit of 1 suppresses that status bit.
- R7: Writing control bit 0 as 1 zeroes every counter on that edge and drops events sampled on the same edge. The status registers are left alone. Bit 0 always reads as 0.
- R8: While control bit 1 (freeze) is set, event pulses do not change any counter.
- R9: While control bit 2 (clear-on-read) is set, a read of a counter returns its value and leaves that counter at zero. An event sampled on the same edge counts from zero.
- R10: `rd_data_o` and `rd_valid_o` appear one cycle after `rd_en_i`. The word addresses are: 0 control, 1 receive status, 2 transmit status, 3 receive mask, 4 transmit mask, 8+i counter i. Any other address, and any unused upper bit, reads as 0.
- R11: Writes to counter addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tx_frame_i | input | 1 | Transmit frame finished, good or bad |
| tx_scol_i | input | 1 | Transmit frame sent after one collision |
| tx_mcol_i | input | 1 | Transmit frame sent after several collisions |
| tx_good_i | input | 1 | Good transmit frame finished, byte count valid |
| tx_good_bytes_i | input | LEN_W | Byte count of the good transmit frame |
| rx_frame_i | input | 1 | Receive frame finished, good or bad |
| rx_crc_err_i | input | 1 | Receive frame with CRC error |
| rx_align_err_i | input | 1 | Receive frame with alignment error |
| rx_good_uni_i | input | 1 | Good unicast receive frame |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write word address |
| wr_data_i | input | DATA_W | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read word address |
| rd_data_o | output | DATA_W | Registered read data |
| rd_valid_o | output | 1 | Read data valid |
| rx_irq_o | output | 1 | Receive interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |

## Verification
The assertions check several rules on every cycle. Read valid follows the read strobe by one cycle. The all-frames transmit counter steps by exactly one on an event. Counters hold while frozen and are zero after a zeroing write. Status bits stay set until they are written to clear. An interrupt rises only from a set status bit. Which counter crosses half range or wraps, the summed byte counts, the effect of masks, clear-on-read, the ignored counter writes and the decoding of unmapped addresses can only be shown by the bench. It runs a long sweep of mixed event patterns on an 8-bit configuration against an arithmetic model, then runs directed cases at the 127/128 and 255/0 boundaries.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int NUM_CNT      = 8;
  localparam int NUM_SIDE     = 4;
  localparam int ADR_CTRL     = 0;
  localparam int ADR_RX_STS   = 1;
  localparam int ADR_TX_STS   = 2;
  localparam int ADR_RX_MSK   = 3;
  localparam int ADR_TX_MSK   = 4;
  localparam int ADR_CNT_BASE = 8;
  localparam int CTRL_ZERO    = 0;
  localparam int CTRL_FREEZE  = 1;
  localparam int CTRL_RDCLR   = 2;

  typedef enum int {
    CNT_TX_ALL   = 0,
    CNT_TX_SCOL  = 1,
    CNT_TX_MCOL  = 2,
    CNT_TX_OCT   = 3,
    CNT_RX_ALL   = 4,
    CNT_RX_CRC   = 5,
    CNT_RX_ALIGN = 6,
    CNT_RX_UNI   = 7
  } cnt_idx_e;
endpackage

// File: rtl/mac_stat_counter.sv
module mac_stat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             zero_i,
  input  logic             rdclr_i,
  input  logic             hold_i,
  input  logic             inc_en_i,
  input  logic [INC_W-1:0] inc_amt_i,
  output logic [W-1:0]     cnt_o,
  output logic             flag_o
);
  logic [W-1:0] cnt_q;
  logic         flag_q;
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic         apply;

  always_comb begin
    base  = rdclr_i ? '0 : cnt_q;
    apply = inc_en_i & ~hold_i & ~zero_i;
    sum   = {1'b0, base} + {{(W + 1 - INC_W){1'b0}}, inc_amt_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || zero_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= apply & (sum[W] | (~base[W-1] & sum[W-1]));
      cnt_q  <= apply ? sum[W-1:0] : base;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/mac_stat_irq.sv
module mac_stat_irq #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] set_i,
  input  logic         sts_we_i,
  input  logic         msk_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] msk_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] msk_q;
  logic         irq_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i)                        sts_q[k] <= 1'b0;
      else if (set_i[k])                sts_q[k] <= 1'b1;
      else if (sts_we_i && wdata_i[k])  sts_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (msk_we_i) msk_q <= wdata_i;
      irq_q <= |(sts_q & ~msk_q);
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mac_stat_ctrl.sv
module mac_stat_ctrl
  import mac_stat_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               zero_o,
  output logic               freeze_o,
  output logic               rdclr_en_o,
  output logic               rx_sts_we_o,
  output logic               tx_sts_we_o,
  output logic               rx_msk_we_o,
  output logic               tx_msk_we_o,
  output logic [NUM_CNT-1:0] cnt_rdclr_o
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_RX_STS = ADDR_W'(ADR_RX_STS);
  localparam logic [ADDR_W-1:0] A_TX_STS = ADDR_W'(ADR_TX_STS);
  localparam logic [ADDR_W-1:0] A_RX_MSK = ADDR_W'(ADR_RX_MSK);
  localparam logic [ADDR_W-1:0] A_TX_MSK = ADDR_W'(ADR_TX_MSK);

  logic ctrl_we;
  logic freeze_q;
  logic rdclr_q;

  assign ctrl_we     = wr_en_i && (wr_addr_i == A_CTRL);
  assign zero_o      = ctrl_we && wr_data_i[CTRL_ZERO];
  assign rx_sts_we_o = wr_en_i && (wr_addr_i == A_RX_STS);
  assign tx_sts_we_o = wr_en_i && (wr_addr_i == A_TX_STS);
  assign rx_msk_we_o = wr_en_i && (wr_addr_i == A_RX_MSK);
  assign tx_msk_we_o = wr_en_i && (wr_addr_i == A_TX_MSK);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      freeze_q <= 1'b0;
      rdclr_q  <= 1'b0;
    end else if (ctrl_we) begin
      freeze_q <= wr_data_i[CTRL_FREEZE];
      rdclr_q  <= wr_data_i[CTRL_RDCLR];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_rdclr
    assign cnt_rdclr_o[i] = rd_en_i && rdclr_q && (rd_addr_i == ADDR_W'(ADR_CNT_BASE + i));
  end

  assign freeze_o   = freeze_q;
  assign rdclr_en_o = rdclr_q;
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tx_frame_i,
  input  logic              tx_scol_i,
  input  logic              tx_mcol_i,
  input  logic              tx_good_i,
  input  logic [LEN_W-1:0]  tx_good_bytes_i,
  input  logic              rx_frame_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_align_err_i,
  input  logic              rx_good_uni_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  localparam int HALF = NUM_CNT / 2;

  logic [NUM_CNT-1:0]            evt;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            flag;
  logic [NUM_CNT-1:0]            cnt_rdclr;
  logic zero, freeze, rdclr_en;
  logic rx_sts_we, tx_sts_we, rx_msk_we, tx_msk_we;
  logic [HALF-1:0] rx_sts, tx_sts, rx_msk, tx_msk;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  assign evt = {rx_good_uni_i, rx_align_err_i, rx_crc_err_i, rx_frame_i,
                tx_good_i, tx_mcol_i, tx_scol_i, tx_frame_i};

  mac_stat_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .zero_o(zero), .freeze_o(freeze), .rdclr_en_o(rdclr_en),
    .rx_sts_we_o(rx_sts_we), .tx_sts_we_o(tx_sts_we),
    .rx_msk_we_o(rx_msk_we), .tx_msk_we_o(tx_msk_we),
    .cnt_rdclr_o(cnt_rdclr)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == CNT_TX_OCT) begin : g_oct
      mac_stat_counter #(.W(CNT_W), .INC_W(LEN_W)) cnt_i (
        .clk_i(clk_i), .rst_i(rst_i), .zero_i(zero), .rdclr_i(cnt_rdclr[i]),
        .hold_i(freeze), .inc_en_i(evt[i]), .inc_amt_i(tx_good_bytes_i),
        .cnt_o(cnt[i]), .flag_o(flag[i])
      );
    end else begin : g_frm
      mac_stat_counter #(.W(CNT_W), .INC_W(1)) cnt_i (
        .clk_i(clk_i), .rst_i(rst_i), .zero_i(zero), .rdclr_i(cnt_rdclr[i]),
        .hold_i(freeze), .inc_en_i(evt[i]), .inc_amt_i(1'b1),
        .cnt_o(cnt[i]), .flag_o(flag[i])
      );
    end
  end

  mac_stat_irq #(.N(HALF)) tx_irq_i (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(flag[HALF-1:0]),
    .sts_we_i(tx_sts_we), .msk_we_i(tx_msk_we), .wdata_i(wr_data_i[HALF-1:0]),
    .sts_o(tx_sts), .msk_o(tx_msk), .irq_o(tx_irq_o)
  );

  mac_stat_irq #(.N(HALF)) rx_irq_i (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(flag[NUM_CNT-1:HALF]),
    .sts_we_i(rx_sts_we), .msk_we_i(rx_msk_we), .wdata_i(wr_data_i[HALF-1:0]),
    .sts_o(rx_sts), .msk_o(rx_msk), .irq_o(rx_irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == ADDR_W'(ADR_CTRL))   rd_mux = DATA_W'({rdclr_en, freeze, 1'b0});
    if (rd_addr_i == ADDR_W'(ADR_RX_STS)) rd_mux = DATA_W'(rx_sts);
    if (rd_addr_i == ADDR_W'(ADR_TX_STS)) rd_mux = DATA_W'(tx_sts);
    if (rd_addr_i == ADDR_W'(ADR_RX_MSK)) rd_mux = DATA_W'(rx_msk);
    if (rd_addr_i == ADDR_W'(ADR_TX_MSK)) rd_mux = DATA_W'(tx_msk);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_addr_i == ADDR_W'(ADR_CNT_BASE + i)) rd_mux = DATA_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk
  import mac_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_i,
  input logic                          tx_frame_i,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i,
  input logic                          rd_en_i,
  input logic [ADDR_W-1:0]             rd_addr_i,
  input logic                          rd_valid_o,
  input logic                          rx_irq_o,
  input logic                          tx_irq_o,
  input logic                          freeze,
  input logic                          rdclr_en,
  input logic [3:0]                    rx_sts,
  input logic [3:0]                    tx_sts,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
  logic ctrl_wr, rx_sts_wr, tx_sts_wr, any_rdclr, tx_all_rdclr;
  assign ctrl_wr      = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
  assign rx_sts_wr    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_RX_STS));
  assign tx_sts_wr    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_TX_STS));
  assign any_rdclr    = rd_en_i && rdclr_en;
  assign tx_all_rdclr = any_rdclr && (rd_addr_i == ADDR_W'(ADR_CNT_BASE));

  assert_rd_valid_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_en_i |=> rd_valid_o);
  assert_rd_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> !rd_valid_o);
  assert_tx_all_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_frame_i && !freeze && !ctrl_wr && !tx_all_rdclr)
    |=> cnt[0] == $past(cnt[0]) + CNT_W'(1));
  assert_freeze_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (freeze && !ctrl_wr && !any_rdclr) |=> $stable(cnt));
  assert_zero_all_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_wr && wr_data_i[CTRL_ZERO]) |=> (cnt == '0));
  assert_rx_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !rx_sts_wr |=> ((rx_sts & $past(rx_sts)) == $past(rx_sts)));
  assert_tx_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !tx_sts_wr |=> ((tx_sts & $past(tx_sts)) == $past(tx_sts)));
  assert_rx_irq_src_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rx_irq_o) |-> $past(|rx_sts));
  assert_tx_irq_src_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(tx_irq_o) |-> $past(|tx_sts));
endmodule

bind mac_stat_bank mac_stat_bank_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .tx_frame_i(tx_frame_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_valid_o(rd_valid_o),
  .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o),
  .freeze(freeze), .rdclr_en(rdclr_en), .rx_sts(rx_sts), .tx_sts(tx_sts), .cnt(cnt)
);

// File: tb/mac_stat_bank_tb_top.sv
module mac_stat_bank_tb_top;
  localparam int CW = 8, LW = 8, AW = 5, DW = 32;
  localparam int RANGE = 1 << CW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic tx_frame, tx_scol, tx_mcol, tx_good, rx_frame, rx_crc, rx_align, rx_uni;
  logic [LW-1:0] tx_bytes;
  logic wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic rd_valid, rx_irq, tx_irq;

  mac_stat_bank #(.CNT_W(CW), .LEN_W(LW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_i(rst),
    .tx_frame_i(tx_frame), .tx_scol_i(tx_scol), .tx_mcol_i(tx_mcol),
    .tx_good_i(tx_good), .tx_good_bytes_i(tx_bytes),
    .rx_frame_i(rx_frame), .rx_crc_err_i(rx_crc), .rx_align_err_i(rx_align),
    .rx_good_uni_i(rx_uni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  int checks = 0, fails = 0;
  int exp_cnt [8];
  logic [3:0] exp_rx, exp_tx, msk_rx, msk_tx;
  bit frz, rdclr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    chk("R10 read valid", 32'(rd_valid), 32'd1);
    if (rdclr && a >= 8 && a < 16) exp_cnt[a-8] = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: begin
        frz = d[1]; rdclr = d[2];
        if (d[0]) for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
      end
      1: exp_rx &= ~d[3:0];
      2: exp_tx &= ~d[3:0];
      3: msk_rx = d[3:0];
      4: msk_tx = d[3:0];
      default: ;
    endcase
  endtask

  task automatic ev(input logic [7:0] m, input int bytes);
    {rx_uni, rx_align, rx_crc, rx_frame, tx_good, tx_mcol, tx_scol, tx_frame} = m;
    tx_bytes = LW'(bytes);
    @(negedge clk);
    {rx_uni, rx_align, rx_crc, rx_frame, tx_good, tx_mcol, tx_scol, tx_frame} = '0;
    if (!frz) begin
      for (int i = 0; i < 8; i++) begin
        if (m[i]) begin
          int inc, old, s;
          inc = (i == 3) ? bytes : 1;
          old = exp_cnt[i];
          s = old + inc;
          if (s >= RANGE || (old < RANGE/2 && (s % RANGE) >= RANGE/2)) begin
            if (i < 4) exp_tx[i] = 1'b1; else exp_rx[i-4] = 1'b1;
          end
          exp_cnt[i] = s % RANGE;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int a = 8; a < 16; a++) begin
      int e;
      e = exp_cnt[a-8];
      rd(a, d);
      chk(req, d, 32'(e));
    end
    rd(1, d); chk("R4 rx status", d, 32'(exp_rx));
    rd(2, d); chk("R4 tx status", d, 32'(exp_tx));
    idle(2);
    chk("R6 rx irq", 32'(rx_irq), 32'(|(exp_rx & ~msk_rx)));
    chk("R6 tx irq", 32'(tx_irq), 32'(|(exp_tx & ~msk_tx)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1;
    {rx_uni, rx_align, rx_crc, rx_frame, tx_good, tx_mcol, tx_scol, tx_frame} = '0;
    tx_bytes = '0; wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
    exp_rx = '0; exp_tx = '0; msk_rx = '0; msk_tx = '0; frz = 0; rdclr = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 rx irq", 32'(rx_irq), 0);
    chk("R1 tx irq", 32'(tx_irq), 0);
    chk("R10 idle valid", 32'(rd_valid), 0);
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk("R1 reset value", d, 0);
    end

    // R2 R3 R4 R5 R6: long sweep of mixed event patterns
    for (int i = 0; i < 600; i++) begin
      ev(8'((i * 29 + 7) ^ (i >> 2)), (i * 53 + 11) % 256);
      if (i % 50 == 49) check_all("R2 R3 counter value");
      if (i % 100 == 99) begin
        wr(1, 32'hF); wr(2, 32'hF);
      end
    end

    // R5: zero written bits leave status alone, ones clear
    ev(8'hFF, 0); idle(1);
    wr(0, 32'h1);
    for (int k = 0; k < 128; k++) ev(8'h11, 0);
    idle(1);
    wr(1, 32'h0); rd(1, d); chk("R5 write zero keeps", d, 32'(exp_rx));
    wr(1, 32'h1); rd(1, d); chk("R5 write one clears", d, 32'(exp_rx));
    chk("R5 bit cleared", d[0], 0);

    // R4: crossing into the upper half at 127 -> 128, and wrap 255 -> 0
    wr(0, 32'h1); wr(1, 32'hF); wr(2, 32'hF);
    for (int k = 0; k < 127; k++) ev(8'h20, 0);
    idle(1); rd(1, d); chk("R4 no flag at 127", d, 0);
    ev(8'h20, 0); idle(1); rd(1, d); chk("R4 flag at 128", d, 32'h2);
    wr(1, 32'h2);
    for (int k = 0; k < 127; k++) ev(8'h20, 0);
    idle(1); rd(1, d); chk("R4 no flag at 255", d, 0);
    ev(8'h20, 0); idle(1); rd(1, d); chk("R4 flag on wrap", d, 32'h2);
    rd(13, d); chk("R2 wrapped to zero", d, 0);
    ev(8'h08, 255); ev(8'h08, 2); idle(1);
    rd(11, d); chk("R3 octet sum wraps", d, 32'd1);
    check_all("R3 octets after wrap");

    // R6: masking
    wr(3, 32'hF); idle(2);
    chk("R6 rx masked", 32'(rx_irq), 0);
    wr(3, 32'h0); idle(2);
    chk("R6 rx unmasked", 32'(rx_irq), 32'(|exp_rx));
    rd(3, d); chk("R6 mask readback", d, 0);

    // R11: counter writes ignored
    wr(8, 32'hAB); wr(11, 32'h5A);
    rd(8, d);  chk("R11 counter write ignored", d, 32'(exp_cnt[0]));
    rd(11, d); chk("R11 octet write ignored", d, 32'(exp_cnt[3]));

    // R7: zero all counters, status untouched
    ev(8'hFF, 9);
    begin
      logic [3:0] srx, stx;
      srx = exp_rx; stx = exp_tx;
      wr(0, 32'h1);
      check_all("R7 counters zeroed");
      chk("R7 rx status kept", 32'(exp_rx), 32'(srx));
      chk("R7 tx status kept", 32'(exp_tx), 32'(stx));
    end
    rd(0, d); chk("R7 zero bit reads 0", d, 0);

    // R8: freeze
    ev(8'hFF, 3);
    wr(0, 32'h2);
    rd(0, d); chk("R8 control readback", d, 32'h2);
    for (int k = 0; k < 5; k++) ev(8'hFF, 7);
    check_all("R8 frozen counters hold");
    wr(0, 32'h0);

    // R9: clear on read
    wr(0, 32'h1);
    wr(0, 32'h4);
    for (int k = 0; k < 3; k++) ev(8'h01, 0);
    rd(8, d); chk("R9 read returns value", d, 32'd3);
    rd(8, d); chk("R9 counter left at zero", d, 0);
    ev(8'h08, 40);
    rd(11, d); chk("R9 octet value", d, 32'd40);
    rd(11, d); chk("R9 octet cleared", d, 0);
    wr(0, 32'h0);

    // R10: unmapped addresses and upper bits
    wr(5, 32'hFFFF_FFFF); wr(20, 32'hFFFF_FFFF);
    rd(5, d);  chk("R10 unmapped 5", d, 0);
    rd(20, d); chk("R10 unmapped 20", d, 0);
    wr(4, 32'hFFFF_FFFF);
    rd(4, d);  chk("R10 mask upper bits zero", d, 32'hF);
    idle(1);
    chk("R10 valid drops", 32'(rd_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule